// File: doc/BRIEF.md
# Two-Line Primary Interrupt Aggregator

This block sits above a set of secondary interrupt banks and condenses their requests into one interrupt per host line. Every bank drives two active-low request wires, one for each host line, and the aggregator keeps a separate summary view for each line in which bit position n always stands for bank n. A host on either line reads its own summary through a byte-wide register port to find which bank is calling, then services that bank directly. The summary never latches: it follows the bank request wires, so a bit drops as soon as the bank withdraws its request.

For bring-up and software testing, a force register can raise summary bits without any bank activity. Its bits appear in both lines' views and drive both outputs until software writes them back to zero. The bank count is a parameter (default six, at most eight). Positions without a bank read as zero everywhere.

Top module: `prim_irq_agg`

## Requirements
- R1: The register at offset 0x01 reads bit n as 1 when bank n holds its line-1 request wire low or force bit n is 1, for every implemented bank n.
- R2: The register at offset 0x02 reads bit n as 1 when bank n holds its line-2 request wire low or force bit n is 1; line-1 request wires have no effect on it.
- R3: The force register at offset 0x03 is written with a byte and read back; a force bit stays set until a write clears it, and it raises the bit in both line views and drives both outputs low.
- R4: Bit positions at or above the bank count read 0 at offsets 0x01, 0x02 and 0x03, even after writing 0xFF to offset 0x03.
- R5: `int1_n` is driven low from the clock edge after the line-1 view becomes non-zero and is high from the edge after it becomes zero; line-2 activity does not affect it.
- R6: `int2_n` follows the line-2 view in the same way, independently of line 1.
- R7: The views are live: reading them clears nothing, and a bit returns to 0 once its bank releases the wire and no force bit holds it.
- R8: Reads of any offset other than 0x01, 0x02 and 0x03 return 0x00; writes to such offsets and to the read-only offsets 0x01 and 0x02 change nothing.
- R9: Synchronous active-low reset clears the force register, drives both outputs high and sets read data to 0x00.
- R10: Read data is captured at the clock edge where `reg_rd_en` is high and holds its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_irq1_n | input | NUM_BANKS | Line-1 request from each bank, active low, bit n = bank n |
| bank_irq2_n | input | NUM_BANKS | Line-2 request from each bank, active low, bit n = bank n |
| reg_addr | input | 8 | Register offset |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| int1_n | output | 1 | Line-1 host interrupt, active low |
| int2_n | output | 1 | Line-2 host interrupt, active low |

## Verification
The line views are driven with single-bank requests, several banks together, and different patterns on the two lines at once, which separates a correct per-bank bit mapping from swapped lines or shifted positions. Force-register writes with and without bank activity distinguish an OR into both views from a copy into one line only, and a 0xFF write exposes any leakage into the unimplemented positions. Repeated reads followed by bank release tell a live view from a latched or clear-on-read one, and accesses to unused and read-only offsets show that only the force register can be written.

// File: rtl/prim_irq_agg_pkg.sv
// Package: shared offsets and the bundled status view for the aggregator.
package prim_irq_agg_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    // Register offsets decoded by the read port and force register.
    typedef enum logic [ADDR_W-1:0] {
        OFF_VIEW_L1 = 8'h01,
        OFF_VIEW_L2 = 8'h02,
        OFF_FORCE   = 8'h03
    } reg_off_e;

    // Everything the read port may return.
    typedef struct packed {
        logic [DATA_W-1:0] view_l1;
        logic [DATA_W-1:0] view_l2;
        logic [DATA_W-1:0] force_bits;
    } agg_view_t;

endpackage

// File: rtl/pia_force_reg.sv
// Module: pia_force_reg
// Holds the software force bits. Only implemented bank positions are stored;
// the remaining positions are tied to zero. Assumes writes are single-cycle
// strobes with a stable address.
module pia_force_reg
    import prim_irq_agg_pkg::*;
#(
    parameter int NUM_BANKS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] force_q
);

    localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((1 << NUM_BANKS) - 1);

    logic hit;

    // Decode a write aimed at the force register.
    always_comb begin
        hit = wr_en && (addr == OFF_FORCE);
    end

    // Load masked write data; keep value otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q <= '0;
        end else if (hit) begin
            force_q <= wdata & IMPL_MASK;
        end
    end

    // R4: unimplemented force positions never hold a one.
    p_force_unimpl_zero_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (force_q & ~IMPL_MASK) == '0);

    // R3: a force bit only changes on a write to the force offset.
    p_force_sticky_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFF_FORCE) |=> $stable(force_q));

endmodule

// File: rtl/pia_line_view.sv
// Module: pia_line_view
// Builds one host line's summary view: bank n's active-low request becomes
// bit n, ORed with the force bits, masked to implemented positions. The line
// output is registered and active low. Assumes bank requests are synchronous
// to clk.
module pia_line_view
    import prim_irq_agg_pkg::*;
#(
    parameter int NUM_BANKS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_req_n,
    input  logic [DATA_W-1:0]    force_bits,
    output logic [DATA_W-1:0]    view,
    output logic                 line_n
);

    localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((1 << NUM_BANKS) - 1);

    logic [DATA_W-1:0] req_wide;

    // Widen the active-high requests to the byte lane, zero above the banks.
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        if (g < NUM_BANKS) begin : g_bank
            assign req_wide[g] = ~bank_req_n[g];
        end else begin : g_empty
            assign req_wide[g] = 1'b0;
        end
    end

    // Live view: requests OR forced bits, implemented lanes only.
    always_comb begin
        view = (req_wide | force_bits) & IMPL_MASK;
    end

    // Register the summary into an active-low line output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_n <= 1'b1;
        end else begin
            line_n <= ~(|view);
        end
    end

endmodule

// File: rtl/pia_read_port.sv
// Module: pia_read_port
// Decodes the read offset and captures the selected byte on a read strobe.
// Undefined offsets return zero. Read data holds between reads.
module pia_read_port
    import prim_irq_agg_pkg::*;
#(
    parameter int NUM_BANKS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  agg_view_t         src,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] sel;

    // Select the byte for the requested offset.
    always_comb begin
        unique case (addr)
            OFF_VIEW_L1: sel = src.view_l1;
            OFF_VIEW_L2: sel = src.view_l2;
            OFF_FORCE:   sel = src.force_bits;
            default:     sel = '0;
        endcase
    end

    // Capture on read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sel;
        end
    end

    // R8: undefined offsets read as zero.
    p_undef_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != OFF_VIEW_L1 && addr != OFF_VIEW_L2 && addr != OFF_FORCE)
        |=> rdata == '0);

    // R10: read data is stable without a read strobe.
    p_rdata_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R4: positions above the bank count never read as one.
    if (NUM_BANKS < DATA_W) begin : g_unimpl_chk
        p_rdata_unimpl_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            rdata[DATA_W-1:NUM_BANKS] == '0);
    end

endmodule

// File: rtl/prim_irq_agg.sv
// Module: prim_irq_agg (top)
// Primary interrupt aggregator: two live per-line views over NUM_BANKS
// secondary banks, a shared force register, a byte register port and two
// active-low host lines. Assumes 1 <= NUM_BANKS <= 8 and synchronous inputs.
module prim_irq_agg
    import prim_irq_agg_pkg::*;
#(
    parameter int NUM_BANKS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_irq1_n,
    input  logic [NUM_BANKS-1:0] bank_irq2_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_rd_en,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 int1_n,
    output logic                 int2_n
);

    logic [DATA_W-1:0] force_q;
    logic [DATA_W-1:0] view_l1;
    logic [DATA_W-1:0] view_l2;
    agg_view_t         view_bus;

    pia_force_reg #(.NUM_BANKS(NUM_BANKS)) u_force (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .force_q (force_q)
    );

    pia_line_view #(.NUM_BANKS(NUM_BANKS)) u_line1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_req_n (bank_irq1_n),
        .force_bits (force_q),
        .view       (view_l1),
        .line_n     (int1_n)
    );

    pia_line_view #(.NUM_BANKS(NUM_BANKS)) u_line2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_req_n (bank_irq2_n),
        .force_bits (force_q),
        .view       (view_l2),
        .line_n     (int2_n)
    );

    // Bundle the readable state for the read port.
    always_comb begin
        view_bus.view_l1    = view_l1;
        view_bus.view_l2    = view_l2;
        view_bus.force_bits = force_q;
    end

    pia_read_port #(.NUM_BANKS(NUM_BANKS)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (reg_rd_en),
        .addr  (reg_addr),
        .src   (view_bus),
        .rdata (reg_rdata)
    );

    // R5: any line-1 bank request drives int1_n low next cycle.
    p_int1_on_bank_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (bank_irq1_n != '1) |=> !int1_n);

    // R6: any line-2 bank request drives int2_n low next cycle.
    p_int2_on_bank_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (bank_irq2_n != '1) |=> !int2_n);

    // R5: a quiet line 1 with no force bits leaves int1_n high.
    p_int1_quiet_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (bank_irq1_n == '1 && force_q == '0) |=> int1_n);

    // R6: a quiet line 2 with no force bits leaves int2_n high.
    p_int2_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        (bank_irq2_n == '1 && force_q == '0) |=> int2_n);

    // R3: force bits drive both lines.
    p_force_both_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (force_q != '0) |=> (!int1_n && !int2_n));

endmodule

// File: tb/prim_irq_agg_bench.sv
module prim_irq_agg_bench;

    localparam int NB = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] b1_n = '1;
    logic [NB-1:0] b2_n = '1;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [7:0]    wdata = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rdata;
    logic          int1_n;
    logic          int2_n;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] force_model = '0;

    always #5 clk = ~clk;

    prim_irq_agg #(.NUM_BANKS(NB)) u_prim_irq_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .bank_irq1_n (b1_n),
        .bank_irq2_n (b2_n),
        .reg_addr    (addr),
        .reg_wr_en   (wr_en),
        .reg_wdata   (wdata),
        .reg_rd_en   (rd_en),
        .reg_rdata   (rdata),
        .int1_n      (int1_n),
        .int2_n      (int2_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] exp_view(input logic [NB-1:0] bn);
        return ({2'b00, ~bn} | force_model) & 8'h3F;
    endfunction

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_both(input string tag);
        logic [7:0] v;
        rd(8'h01, v); chk({tag, " R1 view1"}, v, exp_view(b1_n));
        rd(8'h02, v); chk({tag, " R2 view2"}, v, exp_view(b2_n));
        chk({tag, " R5 int1_n"}, {7'd0, int1_n}, {7'd0, exp_view(b1_n) == 8'h00});
        chk({tag, " R6 int2_n"}, {7'd0, int2_n}, {7'd0, exp_view(b2_n) == 8'h00});
    endtask

    task automatic t_reset();
        chk("R9 reset int1_n", {7'd0, int1_n}, 8'd1);
        chk("R9 reset int2_n", {7'd0, int2_n}, 8'd1);
        chk("R9 reset rdata", rdata, 8'h00);
        begin
            logic [7:0] v;
            rd(8'h03, v); chk("R9 force cleared", v, 8'h00);
        end
    endtask

    task automatic t_patterns();
        b1_n = 6'b111110; b2_n = '1; settle(); check_both("single bank0");
        b1_n = 6'b011111; settle(); check_both("single bank5");
        b1_n = 6'b101010; b2_n = 6'b010101; settle(); check_both("mixed lines");
        b1_n = '1; b2_n = 6'b111011; settle(); check_both("line2 only");
        b1_n = '1; b2_n = '1; settle(); check_both("all quiet");
    endtask

    task automatic t_force();
        logic [7:0] v;
        wr(8'h03, 8'h12); force_model = 8'h12; settle();
        rd(8'h03, v); chk("R3 force readback", v, 8'h12);
        check_both("force only");
        b1_n = 6'b111101; settle(); check_both("force plus bank");
        b1_n = '1; settle();
        rd(8'h03, v); chk("R3 force sticky", v, 8'h12);
        wr(8'h03, 8'h00); force_model = 8'h00; settle();
        check_both("force cleared R3");
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        wr(8'h03, 8'hFF); force_model = 8'h3F; settle();
        rd(8'h03, v); chk("R4 force upper", v, 8'h3F);
        rd(8'h01, v); chk("R4 view1 upper", v, 8'h3F);
        rd(8'h02, v); chk("R4 view2 upper", v, 8'h3F);
        wr(8'h03, 8'h00); force_model = 8'h00; settle();
    endtask

    task automatic t_live();
        logic [7:0] v;
        b2_n = 6'b110111; settle();
        rd(8'h02, v); chk("R7 first read", v, 8'h08);
        rd(8'h02, v); chk("R7 no clear on read", v, 8'h08);
        b2_n = '1; settle();
        rd(8'h02, v); chk("R7 cleared on release", v, 8'h00);
        chk("R7 int2_n released", {7'd0, int2_n}, 8'd1);
    endtask

    task automatic t_undef();
        logic [7:0] v;
        b1_n = 6'b111011; settle();
        rd(8'h00, v); chk("R8 read 0x00", v, 8'h00);
        rd(8'h04, v); chk("R8 read 0x04", v, 8'h00);
        rd(8'hFF, v); chk("R8 read 0xFF", v, 8'h00);
        wr(8'h00, 8'h3F); wr(8'h04, 8'h3F); wr(8'h01, 8'h3F); wr(8'h02, 8'h3F);
        settle();
        rd(8'h03, v); chk("R8 force untouched", v, 8'h00);
        check_both("R8 views untouched");
        b1_n = '1; settle();
    endtask

    task automatic t_hold();
        logic [7:0] v;
        rd(8'h01, v);
        b1_n = 6'b000001; settle();
        chk("R10 rdata holds", rdata, 8'h00);
        rd(8'h01, v); chk("R10 new read", v, 8'h3E);
        b1_n = '1; settle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_force();
        t_unimpl();
        t_live();
        t_undef();
        t_hold();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule